// File: doc/BRIEF.md
# SATA Port Command Slot Tracker

This block keeps the per-slot bookkeeping of a single host adapter port: which command slots software has issued and which native-queued tags are still outstanding on the device. Software sets bits in both vectors and controls a run bit. The command engine reports protocol milestones as single-cycle events. Each event carries a slot index and the three task-file status flags. The block decides, from the event kind and those flags, which bits drop.

The central rule is that a slot stays visible in the issue vector until its command has succeeded. A queued command leaves the issue vector once the device has accepted it. An unqueued command leaves it only on clean completion. Any error, busy or data-request flag keeps the bit set, so software can find the failing slot. Stopping the port clears both vectors. A link reset clears only the issue vector. A small sequencer follows the two-frame legacy software reset, releasing the slots it uses at the correct points.

Top module: `sata_slot_tracker`

## Requirements
- R1: After hardware reset `start_o`, `issue_o` and `active_o` are all zero and `srst_phase_o` is 0 (idle).
- R2: Writes to `issue_wr_mask` / `tag_wr_mask` OR their one bits into the issue / active vector one cycle later while `start_o` is 1; while `start_o` is 0 they are ignored.
- R3: An event of kind 0 (queued) with status 3'b000 clears the slot's issue bit in the next cycle and leaves the active vector unchanged.
- R4: An event of kind 0 (queued) or kind 1 (done) whose status has any of ERR (bit 2), BSY (bit 1) or DRQ (bit 0) set leaves the issue bit set. Kind 1 with status 3'b000 clears it.
- R5: An event of kind 2 (finish) with status 3'b000 clears the slot's active bit. With any status bit set the active bit stays. The issue vector is unaffected.
- R6: An event of kind 3 (error) changes neither vector.
- R7: When a set write and a clear hit the same slot in the same cycle, the bit ends cleared.
- R8: Writing the run bit from 1 to 0 clears both vectors. Writing the run bit with its current value changes nothing.
- R9: A `port_reset` pulse sets the issue vector to zero and leaves the active vector and the run bit unchanged.
- R10: A frame with `fis_srst`=1 and `fis_cbit`=1 clears that slot's issue bit. With `fis_cbit`=0 the bit stays. Either moves the phase to 1 (asserted).
- R11: In phase 1, a frame with `fis_srst`=0 moves the phase to 2 (diagnosing) and records its slot. A kind 1 event on that slot with BSY and DRQ clear then clears its issue bit, even with ERR set, and the phase returns to 0.
- R12: `srst_phase_o` never reads 3. A port reset or run-bit 1-to-0 write returns it to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset |
| start_wr_en | input | 1 | Run-bit write strobe |
| start_wr_val | input | 1 | Run-bit write value |
| issue_wr_en | input | 1 | Issue-set write strobe |
| issue_wr_mask | input | 32 | Slots to mark issued |
| tag_wr_en | input | 1 | Active-tag set write strobe |
| tag_wr_mask | input | 32 | Tags to mark active |
| port_reset | input | 1 | Link-level port reset pulse |
| ev_valid | input | 1 | Engine event pulse |
| ev_kind | input | 2 | 0 queued, 1 done, 2 finish, 3 error |
| ev_slot | input | 5 | Slot of the event |
| ev_status | input | 3 | {ERR, BSY, DRQ} |
| fis_valid | input | 1 | Register frame sent to device |
| fis_slot | input | 5 | Slot carrying the frame |
| fis_srst | input | 1 | Frame asserts software reset |
| fis_cbit | input | 1 | Frame asks adapter to clear its slot |
| start_o | output | 1 | Run bit |
| issue_o | output | 32 | Issue vector |
| active_o | output | 32 | Active-tag vector |
| srst_phase_o | output | 2 | 0 idle, 1 asserted, 2 diagnosing |

## Verification
Every vector bit is a register read straight at the ports. A wrong clear or a missed set therefore shows as a wrong bit in the very next cycle after the event. No later symptom is needed to expose it. The error cases are the ones that matter most. A bit dropped in error hides the failing slot, and a bit kept in error looks like a hung command. The bench reads each vector after every event, with status patterns that touch each flag alone. A sequencer stuck in the wrong phase shows either on `srst_phase_o` or as a diagnostic reply that fails to release its slot.

// File: rtl/slot_trk_pkg.sv
package slot_trk_pkg;
    typedef enum logic [1:0] {
        EV_QUEUED = 2'd0,
        EV_DONE   = 2'd1,
        EV_FINISH = 2'd2,
        EV_ERROR  = 2'd3
    } ev_kind_e;

    typedef enum logic [1:0] {
        SR_IDLE     = 2'd0,
        SR_ASSERTED = 2'd1,
        SR_DIAG     = 2'd2
    } srst_phase_e;

    localparam int ST_ERR = 2;
    localparam int ST_BSY = 1;
    localparam int ST_DRQ = 0;
endpackage

// File: rtl/slot_onehot.sv
module slot_onehot #(
    parameter int NUM_SLOTS = 32,
    parameter int SLOT_W    = $clog2(NUM_SLOTS)
) (
    input  logic                 valid,
    input  logic [SLOT_W-1:0]    idx,
    output logic [NUM_SLOTS-1:0] mask
);
    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_bit
        assign mask[i] = valid && (idx == SLOT_W'(i));
    end
endmodule

// File: rtl/slot_event_decode.sv
module slot_event_decode
    import slot_trk_pkg::*;
#(
    parameter int NUM_SLOTS = 32,
    parameter int SLOT_W    = $clog2(NUM_SLOTS)
) (
    input  logic                 ev_valid,
    input  logic [1:0]           ev_kind,
    input  logic [SLOT_W-1:0]    ev_slot,
    input  logic [2:0]           ev_status,
    output logic [NUM_SLOTS-1:0] clr_issue,
    output logic [NUM_SLOTS-1:0] clr_active
);
    logic                 clean;
    logic                 hit_issue;
    logic                 hit_active;
    logic [NUM_SLOTS-1:0] slot_mask;

    always_comb begin
        clean      = (ev_status == 3'b000);
        hit_issue  = clean && ((ev_kind_e'(ev_kind) == EV_QUEUED) ||
                               (ev_kind_e'(ev_kind) == EV_DONE));
        hit_active = clean && (ev_kind_e'(ev_kind) == EV_FINISH);
    end

    slot_onehot #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)) u_dec (
        .valid (ev_valid),
        .idx   (ev_slot),
        .mask  (slot_mask)
    );

    assign clr_issue  = hit_issue  ? slot_mask : '0;
    assign clr_active = hit_active ? slot_mask : '0;
endmodule

// File: rtl/srst_seq.sv
module srst_seq
    import slot_trk_pkg::*;
#(
    parameter int NUM_SLOTS = 32,
    parameter int SLOT_W    = $clog2(NUM_SLOTS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 flush,
    input  logic                 fis_valid,
    input  logic [SLOT_W-1:0]    fis_slot,
    input  logic                 fis_srst,
    input  logic                 fis_cbit,
    input  logic                 ev_valid,
    input  logic [1:0]           ev_kind,
    input  logic [SLOT_W-1:0]    ev_slot,
    input  logic                 ev_bsy,
    input  logic                 ev_drq,
    output logic [1:0]           phase,
    output logic [NUM_SLOTS-1:0] clr_mask
);
    typedef struct packed {
        srst_phase_e       ph;
        logic [SLOT_W-1:0] slot;
    } seq_t;

    seq_t seq_d, seq_q;

    logic                 assert_clr;
    logic                 diag_done;
    logic [NUM_SLOTS-1:0] assert_mask;
    logic [NUM_SLOTS-1:0] diag_mask;

    always_comb begin
        assert_clr = fis_valid && fis_srst && fis_cbit;
        diag_done  = (seq_q.ph == SR_DIAG) && ev_valid &&
                     (ev_kind_e'(ev_kind) == EV_DONE) &&
                     (ev_slot == seq_q.slot) && !ev_bsy && !ev_drq;

        seq_d = seq_q;
        if (flush) begin
            seq_d.ph = SR_IDLE;
        end else if (fis_valid && fis_srst) begin
            seq_d.ph = SR_ASSERTED;
        end else begin
            case (seq_q.ph)
                SR_ASSERTED: begin
                    if (fis_valid) begin
                        seq_d.ph   = SR_DIAG;
                        seq_d.slot = fis_slot;
                    end
                end
                SR_DIAG: begin
                    if (diag_done) begin
                        seq_d.ph = SR_IDLE;
                    end
                end
                default: seq_d.ph = SR_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{ph: SR_IDLE, slot: '0};
        end else begin
            seq_q <= seq_d;
        end
    end

    slot_onehot #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)) u_assert_dec (
        .valid (assert_clr),
        .idx   (fis_slot),
        .mask  (assert_mask)
    );

    slot_onehot #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)) u_diag_dec (
        .valid (diag_done),
        .idx   (seq_q.slot),
        .mask  (diag_mask)
    );

    assign clr_mask = assert_mask | diag_mask;
    assign phase    = seq_q.ph;
endmodule

// File: rtl/sata_slot_tracker.sv
module sata_slot_tracker
    import slot_trk_pkg::*;
#(
    parameter int NUM_SLOTS = 32,
    localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_wr_en,
    input  logic                 start_wr_val,
    input  logic                 issue_wr_en,
    input  logic [NUM_SLOTS-1:0] issue_wr_mask,
    input  logic                 tag_wr_en,
    input  logic [NUM_SLOTS-1:0] tag_wr_mask,
    input  logic                 port_reset,
    input  logic                 ev_valid,
    input  logic [1:0]           ev_kind,
    input  logic [SLOT_W-1:0]    ev_slot,
    input  logic [2:0]           ev_status,
    input  logic                 fis_valid,
    input  logic [SLOT_W-1:0]    fis_slot,
    input  logic                 fis_srst,
    input  logic                 fis_cbit,
    output logic                 start_o,
    output logic [NUM_SLOTS-1:0] issue_o,
    output logic [NUM_SLOTS-1:0] active_o,
    output logic [1:0]           srst_phase_o
);
    typedef struct packed {
        logic                 start;
        logic [NUM_SLOTS-1:0] issue;
        logic [NUM_SLOTS-1:0] active;
    } port_state_t;

    port_state_t st_d, st_q;

    logic                 stop_fall;
    logic                 flush;
    logic [NUM_SLOTS-1:0] ev_clr_issue;
    logic [NUM_SLOTS-1:0] ev_clr_active;
    logic [NUM_SLOTS-1:0] sr_clr_issue;
    logic [NUM_SLOTS-1:0] set_issue;
    logic [NUM_SLOTS-1:0] set_active;

    slot_event_decode #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)) u_evdec (
        .ev_valid   (ev_valid),
        .ev_kind    (ev_kind),
        .ev_slot    (ev_slot),
        .ev_status  (ev_status),
        .clr_issue  (ev_clr_issue),
        .clr_active (ev_clr_active)
    );

    srst_seq #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)) u_srst (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .fis_valid (fis_valid),
        .fis_slot  (fis_slot),
        .fis_srst  (fis_srst),
        .fis_cbit  (fis_cbit),
        .ev_valid  (ev_valid),
        .ev_kind   (ev_kind),
        .ev_slot   (ev_slot),
        .ev_bsy    (ev_status[ST_BSY]),
        .ev_drq    (ev_status[ST_DRQ]),
        .phase     (srst_phase_o),
        .clr_mask  (sr_clr_issue)
    );

    always_comb begin
        stop_fall  = start_wr_en && !start_wr_val && st_q.start;
        flush      = stop_fall || port_reset;
        set_issue  = (st_q.start && issue_wr_en) ? issue_wr_mask : '0;
        set_active = (st_q.start && tag_wr_en)   ? tag_wr_mask   : '0;

        st_d = st_q;
        if (start_wr_en) begin
            st_d.start = start_wr_val;
        end

        // clears are applied after sets so they win on a shared slot
        st_d.issue  = (st_q.issue  | set_issue)  & ~(ev_clr_issue | sr_clr_issue);
        st_d.active = (st_q.active | set_active) & ~ev_clr_active;

        if (port_reset) begin
            st_d.issue = '0;
        end
        if (stop_fall) begin
            st_d.issue  = '0;
            st_d.active = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign start_o  = st_q.start;
    assign issue_o  = st_q.issue;
    assign active_o = st_q.active;
endmodule

// File: rtl/slot_trk_checker.sv
module slot_trk_checker #(
    parameter int NUM_SLOTS = 32,
    parameter int SLOT_W    = $clog2(NUM_SLOTS)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 start_wr_en,
    input logic                 start_wr_val,
    input logic                 port_reset,
    input logic                 ev_valid,
    input logic [1:0]           ev_kind,
    input logic [SLOT_W-1:0]    ev_slot,
    input logic [2:0]           ev_status,
    input logic                 fis_valid,
    input logic                 fis_srst,
    input logic                 fis_cbit,
    input logic                 start_o,
    input logic [NUM_SLOTS-1:0] issue_o,
    input logic [NUM_SLOTS-1:0] active_o,
    input logic [1:0]           srst_phase_o
);
    logic stopping;
    assign stopping = start_wr_en && !start_wr_val;

    AST_STOP_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(start_o) |-> (issue_o == '0) && (active_o == '0)); // R8

    AST_NO_SET_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        !start_o |=> ((issue_o & ~$past(issue_o)) == '0) &&
                     ((active_o & ~$past(active_o)) == '0)); // R2

    AST_LINK_RESET_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        port_reset |=> (issue_o == '0)); // R9

    AST_LINK_RESET_KEEPS_TAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (port_reset && !stopping && !ev_valid) |=>
            (($past(active_o) & ~active_o) == '0)); // R9

    AST_QUEUED_FAIL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && ev_kind == 2'd0 && ev_status != 3'b000 && issue_o[ev_slot] &&
         !port_reset && !stopping && !(fis_valid && fis_srst && fis_cbit))
            |=> issue_o[$past(ev_slot)]); // R4

    AST_PHASE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        srst_phase_o != 2'd3); // R12
endmodule

bind sata_slot_tracker slot_trk_checker #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_wr_en  (start_wr_en),
    .start_wr_val (start_wr_val),
    .port_reset   (port_reset),
    .ev_valid     (ev_valid),
    .ev_kind      (ev_kind),
    .ev_slot      (ev_slot),
    .ev_status    (ev_status),
    .fis_valid    (fis_valid),
    .fis_srst     (fis_srst),
    .fis_cbit     (fis_cbit),
    .start_o      (start_o),
    .issue_o      (issue_o),
    .active_o     (active_o),
    .srst_phase_o (srst_phase_o)
);

// File: tb/sata_slot_tracker_bench.sv
module sata_slot_tracker_bench;
    localparam int N = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_wr_en = 0, start_wr_val = 0;
    logic          issue_wr_en = 0, tag_wr_en = 0, port_reset = 0;
    logic [N-1:0]  issue_wr_mask = '0, tag_wr_mask = '0;
    logic          ev_valid = 0;
    logic [1:0]    ev_kind = '0;
    logic [4:0]    ev_slot = '0;
    logic [2:0]    ev_status = '0;
    logic          fis_valid = 0, fis_srst = 0, fis_cbit = 0;
    logic [4:0]    fis_slot = '0;
    logic          start_o;
    logic [N-1:0]  issue_o, active_o;
    logic [1:0]    srst_phase_o;

    int compared = 0;
    int mismatched = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    sata_slot_tracker u_sata_slot_tracker (.*);

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        start_wr_en = 0; issue_wr_en = 0; tag_wr_en = 0; port_reset = 0;
        ev_valid = 0; fis_valid = 0;
    endtask

    task automatic wr_start(input logic v);
        start_wr_en = 1; start_wr_val = v; step();
    endtask

    task automatic wr_issue(input logic [N-1:0] m);
        issue_wr_en = 1; issue_wr_mask = m; step();
    endtask

    task automatic wr_tag(input logic [N-1:0] m);
        tag_wr_en = 1; tag_wr_mask = m; step();
    endtask

    task automatic event_pulse(input logic [1:0] k, input logic [4:0] s, input logic [2:0] st);
        ev_valid = 1; ev_kind = k; ev_slot = s; ev_status = st; step();
    endtask

    task automatic fis_pulse(input logic [4:0] s, input logic sr, input logic c);
        fis_valid = 1; fis_slot = s; fis_srst = sr; fis_cbit = c; step();
    endtask

    task automatic t_reset();
        check("R1 start", 64'(start_o), 64'd0);
        check("R1 issue", 64'(issue_o), 64'd0);
        check("R1 active", 64'(active_o), 64'd0);
        check("R1 phase", 64'(srst_phase_o), 64'd0);
    endtask

    task automatic t_writes();
        wr_issue(32'hFFFF_0000);
        wr_tag(32'h0000_FFFF);
        check("R2 issue stopped", 64'(issue_o), 64'd0);
        check("R2 tag stopped", 64'(active_o), 64'd0);
        wr_start(1'b1);
        wr_issue(32'h0000_00F1);
        check("R2 issue set", 64'(issue_o), 64'h0000_00F1);
        wr_tag(32'h0000_0030);
        check("R2 tag set", 64'(active_o), 64'h30);
    endtask

    task automatic t_queued();
        event_pulse(2'd0, 5'd4, 3'b000);
        check("R3 queued clears", 64'(issue_o), 64'hE1);
        check("R3 active kept", 64'(active_o), 64'h30);
        event_pulse(2'd0, 5'd5, 3'b010);
        check("R4 queued busy holds", 64'(issue_o), 64'hE1);
    endtask

    task automatic t_done();
        event_pulse(2'd1, 5'd0, 3'b000);
        check("R4 done clears", 64'(issue_o), 64'hE0);
        event_pulse(2'd1, 5'd6, 3'b100);
        check("R4 done err holds", 64'(issue_o), 64'hE0);
        event_pulse(2'd1, 5'd7, 3'b001);
        check("R4 done drq holds", 64'(issue_o), 64'hE0);
    endtask

    task automatic t_finish();
        event_pulse(2'd2, 5'd4, 3'b000);
        check("R5 finish clears", 64'(active_o), 64'h20);
        event_pulse(2'd2, 5'd5, 3'b100);
        check("R5 finish err holds", 64'(active_o), 64'h20);
        check("R5 issue untouched", 64'(issue_o), 64'hE0);
    endtask

    task automatic t_error_kind();
        event_pulse(2'd3, 5'd5, 3'b000);
        check("R6 issue", 64'(issue_o), 64'hE0);
        check("R6 active", 64'(active_o), 64'h20);
    endtask

    task automatic t_priority();
        issue_wr_en = 1; issue_wr_mask = 32'h2;
        ev_valid = 1; ev_kind = 2'd1; ev_slot = 5'd1; ev_status = 3'b000;
        step();
        check("R7 clear wins", 64'(issue_o), 64'hE0);
        wr_issue(32'h8000_0000);
        check("R7 top slot set", 64'(issue_o), 64'h8000_00E0);
    endtask

    task automatic t_port_reset();
        port_reset = 1; step();
        check("R9 issue zero", 64'(issue_o), 64'd0);
        check("R9 active kept", 64'(active_o), 64'h20);
        check("R9 start kept", 64'(start_o), 64'd1);
    endtask

    task automatic t_srst();
        wr_issue(32'h3);
        fis_pulse(5'd0, 1'b1, 1'b0);
        check("R10 no cbit holds", 64'(issue_o), 64'h3);
        check("R12 phase asserted", 64'(srst_phase_o), 64'd1);
        fis_pulse(5'd0, 1'b1, 1'b1);
        check("R10 cbit clears", 64'(issue_o), 64'h2);
        fis_pulse(5'd1, 1'b0, 1'b0);
        check("R11 phase diag", 64'(srst_phase_o), 64'd2);
        check("R11 slot held", 64'(issue_o), 64'h2);
        event_pulse(2'd1, 5'd1, 3'b010);
        check("R11 busy reply holds", 64'(issue_o), 64'h2);
        check("R11 still diag", 64'(srst_phase_o), 64'd2);
        event_pulse(2'd1, 5'd1, 3'b100);
        check("R11 reply clears", 64'(issue_o), 64'd0);
        check("R11 phase idle", 64'(srst_phase_o), 64'd0);
    endtask

    task automatic t_stop();
        wr_tag(32'h3);
        wr_issue(32'h5);
        wr_start(1'b1);
        check("R8 same value issue", 64'(issue_o), 64'h5);
        check("R8 same value active", 64'(active_o), 64'h23);
        fis_pulse(5'd9, 1'b1, 1'b0);
        check("R12 asserted before stop", 64'(srst_phase_o), 64'd1);
        wr_start(1'b0);
        check("R8 issue cleared", 64'(issue_o), 64'd0);
        check("R8 active cleared", 64'(active_o), 64'd0);
        check("R8 start low", 64'(start_o), 64'd0);
        check("R12 phase idle", 64'(srst_phase_o), 64'd0);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_writes();
        t_queued();
        t_done();
        t_finish();
        t_error_kind();
        t_priority();
        t_port_reset();
        t_srst();
        t_stop();
        finished = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog: actual hung expected completion");
            summary();
            $finish;
        end
    end
endmodule